// File: doc/BRIEF.md
# Serial Converter Frame Reader

This block sits on the host side of a three-wire serial link to a 16-bit delta-sigma converter. On a start request it drops chip select, runs a serial clock derived from a programmable half-period divider, and captures 19 data bits on the rising edges of that clock. It then turns the captured frame into a raw 16-bit code, a signed 17-bit value, and flags for overrange, underrange and a malformed frame. When the read is over it gives a one-cycle done pulse.

The frame starts with three status bits. The first is the end-of-conversion marker, which must be 0. The second is a filler bit, which must also be 0. The third is the sign. The 16 result bits follow, most significant first. The sign together with the result MSB encodes out-of-range inputs. The serial clock is held low while chip select falls, so the converter treats the clock as driven from outside.

Before clocking starts, the data line carries the conversion status. In polling mode the reader waits for that line to go low. If it stays high past a programmable number of cycles, the read is given up.

Top module: `adc_frame_reader`

## Requirements
- R1: During and after reset, csN is 1, sclk is 0, done is 0, and code, value, overRange, underRange and frameErr are all 0.
- R2: A start pulse in idle drives csN low while sclk is low. sclk then stays low for 2·H clock cycles before its first rise, where H is halfPeriod with 0 treated as 1. A start pulse during a read is ignored and produces no extra done.
- R3: A completed read gives exactly 19 rising edges of sclk. Each high phase and each low phase lasts H clock cycles.
- R4: Data is captured at each sclk rise. The first captured bit is the end-of-conversion bit (bit 18), then the filler bit (bit 17), then the sign (bit 16), then 16 result bits MSB first. The code output is those 16 bits.
- R5: value is the 17-bit two's-complement result of {sign, code} − 65536. Sign 1 with code 0 gives 0, and sign 0 with code 0xFFFF gives −1.
- R6: overRange is 1 exactly when sign = 1 and code[15] = 1. underRange is 1 exactly when sign = 0 and code[15] = 0.
- R7: After a completed read, frameErr is 1 exactly when the captured end-of-conversion bit or the filler bit is 1.
- R8: done is a pulse one clock cycle wide, in the cycle where csN returns high. The results change only at that moment and then hold until the next done.
- R9: With pollEoc = 1, after the lead-in the reader waits while the data line is 1 and starts clocking once it reads 0. If the line stays 1 for eocTimeout cycles (0 counts as 1), the read is abandoned: csN returns high with no sclk edge, done pulses, frameErr = 1, overRange = underRange = 0, and code and value keep their previous values.
- R10: With pollEoc = 0, clocking starts after the lead-in whatever the data line shows, so a read begun during a conversion ends with frameErr = 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Request one frame read (used in idle only) |
| pollEoc | input | 1 | Wait for end of conversion before clocking |
| halfPeriod | input | DIV_W | Serial clock half period in clk cycles (0 acts as 1) |
| eocTimeout | input | TMO_W | Poll wait limit in clk cycles (0 acts as 1) |
| sdi | input | 1 | Serial data from the converter |
| csN | output | 1 | Active-low chip select to the converter |
| sclk | output | 1 | Serial clock to the converter |
| code | output | CODE_W | Raw result bits of the last read |
| value | output | CODE_W+1 | Signed result: {sign, code} − 2^CODE_W |
| overRange | output | 1 | Input at or above positive full scale |
| underRange | output | 1 | Input below negative full scale |
| frameErr | output | 1 | Bad status bits or poll timeout |
| done | output | 1 | One-cycle pulse at the end of a read |

## Verification
If the phase or bit counter is wrong, the number of sclk rises or the width of the high phase changes. This is visible at the done pulse of that same read. If the capture shifts by even one position, every later bit moves. The code, the sign-derived value and the range flags then disagree with the driven frame at the first done. A poll state that sticks or leaks shows as a clock edge during an abandoned read, or as a missing or extra done. The reference model counts done pulses against requests, so such a fault is caught within one frame.

// File: rtl/adcrd_pkg.sv
package adcrd_pkg;
  localparam int FRAME_BITS = 19;

  typedef enum logic [2:0] {
    ST_IDLE, ST_LEAD, ST_POLL, ST_LOW, ST_HIGH, ST_DONE
  } rdState_t;

  typedef struct packed {
    logic clear;
    logic capture;
    logic finish;
    logic abort;
  } dpCtl_t;
endpackage

// File: rtl/adcrd_ctrl.sv
module adcrd_ctrl
  import adcrd_pkg::*;
#(
  parameter int DIV_W = 8,
  parameter int TMO_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  input  logic             pollEoc,
  input  logic [DIV_W-1:0] halfPeriod,
  input  logic [TMO_W-1:0] eocTimeout,
  input  logic             sdi,
  output logic             csN,
  output logic             sclk,
  output logic             done,
  output dpCtl_t           ctl
);
  localparam int BIT_W = $clog2(FRAME_BITS);

  rdState_t         state;
  logic [DIV_W-1:0] phCnt;
  logic [DIV_W-1:0] hLat;
  logic [DIV_W-1:0] hEff;
  logic [BIT_W-1:0] bitCnt;
  logic [TMO_W-1:0] waitCnt;
  logic [TMO_W-1:0] tmoLat;
  logic             pollLat;
  logic             phEnd;
  logic             lastBit;
  logic             waitOver;

  always_comb begin
    hEff     = (hLat == '0) ? DIV_W'(1) : hLat;
    phEnd    = (phCnt == hEff - DIV_W'(1));
    lastBit  = (bitCnt == BIT_W'(FRAME_BITS - 1));
    waitOver = (tmoLat == '0) || (waitCnt == tmoLat - TMO_W'(1));
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      phCnt   <= '0;
      hLat    <= '0;
      bitCnt  <= '0;
      waitCnt <= '0;
      tmoLat  <= '0;
      pollLat <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (start) begin
            state   <= ST_LEAD;
            hLat    <= halfPeriod;
            tmoLat  <= eocTimeout;
            pollLat <= pollEoc;
            phCnt   <= '0;
            bitCnt  <= '0;
            waitCnt <= '0;
          end
        end
        ST_LEAD: begin
          if (phEnd) begin
            phCnt <= '0;
            state <= pollLat ? ST_POLL : ST_LOW;
          end else begin
            phCnt <= phCnt + DIV_W'(1);
          end
        end
        ST_POLL: begin
          if (!sdi) begin
            state <= ST_LOW;
            phCnt <= '0;
          end else if (waitOver) begin
            state <= ST_DONE;
          end else begin
            waitCnt <= waitCnt + TMO_W'(1);
          end
        end
        ST_LOW: begin
          if (phEnd) begin
            phCnt <= '0;
            state <= ST_HIGH;
          end else begin
            phCnt <= phCnt + DIV_W'(1);
          end
        end
        ST_HIGH: begin
          if (phEnd) begin
            phCnt <= '0;
            if (lastBit) begin
              state <= ST_DONE;
            end else begin
              bitCnt <= bitCnt + BIT_W'(1);
              state  <= ST_LOW;
            end
          end else begin
            phCnt <= phCnt + DIV_W'(1);
          end
        end
        ST_DONE: state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    ctl.clear   = (state == ST_IDLE) && start;
    ctl.capture = (state == ST_LOW) && phEnd;
    ctl.finish  = (state == ST_HIGH) && phEnd && lastBit;
    ctl.abort   = (state == ST_POLL) && sdi && waitOver;
    csN         = (state == ST_IDLE) || (state == ST_DONE);
    sclk        = (state == ST_HIGH);
    done        = (state == ST_DONE);
  end

  // R3: the bit counter never passes the last frame bit
  a_r3_bit_range: assert property (@(posedge clk) disable iff (!rstN)
    bitCnt < BIT_W'(FRAME_BITS));

  // R2: each clock rise follows a low phase
  a_r2_rise_after_low: assert property (@(posedge clk) disable iff (!rstN)
    $rose(sclk) |-> $past(state) == ST_LOW);

  // R9: the poll wait stays within the programmed limit
  a_r9_wait_bound: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_POLL) |-> (tmoLat == '0 || waitCnt < tmoLat));

  // R8: done lasts a single cycle
  a_r8_done_pulse: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // R2: chip select falls only while the clock is low
  a_r2_cs_quiet: assert property (@(posedge clk) disable iff (!rstN)
    $fell(csN) |-> !sclk && $past(!sclk));
endmodule

// File: rtl/adcrd_dp.sv
module adcrd_dp
  import adcrd_pkg::*;
#(
  parameter int CODE_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sdi,
  input  dpCtl_t            ctl,
  output logic [CODE_W-1:0] code,
  output logic signed [CODE_W:0] value,
  output logic              overRange,
  output logic              underRange,
  output logic              frameErr
);
  localparam int FRAME_W = CODE_W + 3;

  logic [FRAME_W-1:0] shReg;
  logic [CODE_W:0]    offsetVal;
  logic               eocBit;
  logic               dmyBit;
  logic               sigBit;
  logic               msbBit;

  always_comb begin
    eocBit    = shReg[CODE_W+2];
    dmyBit    = shReg[CODE_W+1];
    sigBit    = shReg[CODE_W];
    msbBit    = shReg[CODE_W-1];
    offsetVal = shReg[CODE_W:0] - {1'b1, {CODE_W{1'b0}}};
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shReg      <= '0;
      code       <= '0;
      value      <= '0;
      overRange  <= 1'b0;
      underRange <= 1'b0;
      frameErr   <= 1'b0;
    end else begin
      if (ctl.clear) begin
        shReg <= '0;
      end else if (ctl.capture) begin
        shReg <= {shReg[FRAME_W-2:0], sdi};
      end
      if (ctl.finish) begin
        code       <= shReg[CODE_W-1:0];
        value      <= $signed(offsetVal);
        overRange  <= sigBit & msbBit;
        underRange <= ~sigBit & ~msbBit;
        frameErr   <= eocBit | dmyBit;
      end else if (ctl.abort) begin
        overRange  <= 1'b0;
        underRange <= 1'b0;
        frameErr   <= 1'b1;
      end
    end
  end

  // R6: the two range flags never appear together
  a_r6_flags_exclusive: assert property (@(posedge clk) disable iff (!rstN)
    !(overRange && underRange));

  // R6: overrange implies a value in the top half of the positive range
  a_r6_over_value: assert property (@(posedge clk) disable iff (!rstN)
    overRange |-> value >= $signed({2'b01, {(CODE_W-1){1'b0}}}));

  // R9: an abandoned read leaves an error and no range flag
  a_r9_abort_err: assert property (@(posedge clk) disable iff (!rstN)
    ctl.abort |=> frameErr && !overRange && !underRange);

  // R8: the code holds when no read ends
  a_r8_code_hold: assert property (@(posedge clk) disable iff (!rstN)
    !$past(ctl.finish) |-> $stable(code));
endmodule

// File: rtl/adc_frame_reader.sv
module adc_frame_reader
  import adcrd_pkg::*;
#(
  parameter int DIV_W  = 8,
  parameter int TMO_W  = 16,
  parameter int CODE_W = 16
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   start,
  input  logic                   pollEoc,
  input  logic [DIV_W-1:0]       halfPeriod,
  input  logic [TMO_W-1:0]       eocTimeout,
  input  logic                   sdi,
  output logic                   csN,
  output logic                   sclk,
  output logic [CODE_W-1:0]      code,
  output logic signed [CODE_W:0] value,
  output logic                   overRange,
  output logic                   underRange,
  output logic                   frameErr,
  output logic                   done
);
  dpCtl_t ctl;

  adcrd_ctrl #(.DIV_W(DIV_W), .TMO_W(TMO_W)) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .start      (start),
    .pollEoc    (pollEoc),
    .halfPeriod (halfPeriod),
    .eocTimeout (eocTimeout),
    .sdi        (sdi),
    .csN        (csN),
    .sclk       (sclk),
    .done       (done),
    .ctl        (ctl)
  );

  adcrd_dp #(.CODE_W(CODE_W)) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .sdi        (sdi),
    .ctl        (ctl),
    .code       (code),
    .value      (value),
    .overRange  (overRange),
    .underRange (underRange),
    .frameErr   (frameErr)
  );
endmodule

// File: tb/sim_adc_frame_reader.sv
module sim_adc_frame_reader;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic        rstN = 1'b0;
  logic        start = 1'b0;
  logic        pollEoc = 1'b0;
  logic [7:0]  halfPeriod = 8'd1;
  logic [15:0] eocTimeout = 16'd1;
  logic        sdi;
  wire         csN, sclk, overRange, underRange, frameErr, done;
  wire [15:0]  code;
  wire signed [16:0] value;

  adc_frame_reader u0 (
    .clk(clk), .rstN(rstN), .start(start), .pollEoc(pollEoc),
    .halfPeriod(halfPeriod), .eocTimeout(eocTimeout), .sdi(sdi),
    .csN(csN), .sclk(sclk), .code(code), .value(value),
    .overRange(overRange), .underRange(underRange),
    .frameErr(frameErr), .done(done)
  );

  // converter model: status bit until first fall, then frame bits, then ones
  logic        conv = 1'b0;
  logic [18:0] frm = '0;
  int          idx = 18;
  always @(negedge csN) idx = 18;
  always @(negedge sclk) if (csN === 1'b0) idx = idx - 1;
  always_comb begin
    if (csN !== 1'b0)   sdi = 1'b1;
    else if (idx == 18) sdi = conv;
    else if (idx >= 0)  sdi = frm[idx];
    else                sdi = 1'b1;
  end

  typedef struct {
    logic [15:0] c;
    int v;
    bit ov, un, er;
    int rises, lead, hi;
  } exp_t;

  exp_t q[$];
  int checks = 0, errors = 0;
  logic [15:0] lastC = '0;
  int lastV = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual %0d expected %0d", req, what, act, expv);
    end
  endtask

  task automatic runFrame(input logic [18:0] f, input bit cv, input bit poll,
                          input int h, input int tmo, input int clearAfter,
                          input bit extraStart);
    exp_t e;
    int hE;
    hE = (h == 0) ? 1 : h;
    if (poll && cv && clearAfter < 0) begin
      e.c = lastC; e.v = lastV; e.ov = 0; e.un = 0; e.er = 1;
      e.rises = 0; e.lead = -1; e.hi = -1;
    end else begin
      e.c = f[15:0];
      e.v = f[16] ? int'(f[15:0]) : int'(f[15:0]) - 65536;
      e.ov = f[16] & f[15];
      e.un = !f[16] & !f[15];
      e.er = (poll ? 1'b0 : cv) | f[17];
      e.rises = 19; e.lead = poll ? -1 : 2 * hE; e.hi = hE;
      lastC = e.c; lastV = e.v;
    end
    frm = f; conv = cv; pollEoc = poll;
    halfPeriod = 8'(h); eocTimeout = 16'(tmo);
    q.push_back(e);
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    if (extraStart) begin
      repeat (10) @(negedge clk);
      start = 1'b1;
      @(negedge clk) start = 1'b0;
    end
    if (clearAfter >= 0) begin
      repeat (clearAfter) @(negedge clk);
      conv = 1'b0;
    end
    while (q.size() != 0) @(negedge clk);
    conv = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  // monitor / scoreboard
  bit prevCs = 1, prevSclk = 0, prevDone = 0;
  int rises = 0, lead = 0, hiRun = 0, lastHi = 0;
  always @(negedge clk) if (rstN) begin
    exp_t e;
    if (prevCs && !csN) begin
      chk(sclk == 1'b0, "R2", "sclk at cs fall", int'(sclk), 0);
      rises = 0; lead = 0; hiRun = 0; lastHi = 0;
    end
    if (!csN) begin
      if (sclk && !prevSclk) rises++;
      if (!sclk && rises == 0) lead++;
    end
    if (sclk) hiRun++;
    else if (hiRun > 0) begin lastHi = hiRun; hiRun = 0; end
    if (done && prevDone) chk(0, "R8", "done wider than one cycle", 2, 1);
    if (done) begin
      chk(csN == 1'b1, "R8", "csN with done", int'(csN), 1);
      if (q.size() == 0) chk(0, "R2", "unexpected done", 1, 0);
      else begin
        e = q.pop_front();
        chk(code == e.c, "R4", "code", int'(code), int'(e.c));
        chk(int'(value) == e.v, "R5", "value", int'(value), e.v);
        chk(overRange == e.ov, "R6", "overRange", int'(overRange), int'(e.ov));
        chk(underRange == e.un, "R6", "underRange", int'(underRange), int'(e.un));
        chk(frameErr == e.er, "R7", "frameErr", int'(frameErr), int'(e.er));
        chk(rises == e.rises, "R3", "sclk rises", rises, e.rises);
        if (e.lead >= 0) chk(lead == e.lead, "R2", "lead-in cycles", lead, e.lead);
        if (e.hi >= 0) chk(lastHi == e.hi, "R3", "high phase", lastHi, e.hi);
      end
    end
    if (prevDone && !done) begin
      chk(code == lastC, "R8", "code hold", int'(code), int'(lastC));
    end
    prevCs = csN; prevSclk = sclk; prevDone = done;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(csN == 1'b1, "R1", "reset csN", int'(csN), 1);
    chk(sclk == 1'b0, "R1", "reset sclk", int'(sclk), 0);
    chk(done == 1'b0, "R1", "reset done", int'(done), 0);
    chk(code == 16'h0 && value == 0, "R1", "reset code", int'(code), 0);
    chk(!frameErr && !overRange && !underRange, "R1", "reset flags",
        int'(frameErr), 0);
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    // R5 zero input and minus one LSB
    runFrame({2'b00, 1'b1, 16'h0000}, 0, 0, 1, 10, -1, 0);
    runFrame({2'b00, 1'b0, 16'hFFFF}, 0, 0, 2, 10, -1, 0);
    // R6 overrange and underrange
    runFrame({2'b00, 1'b1, 16'h8000}, 0, 0, 3, 10, -1, 0);
    runFrame({2'b00, 1'b0, 16'h7FFF}, 0, 0, 1, 10, -1, 0);
    // R3 half period 0 acts as 1
    runFrame({2'b00, 1'b1, 16'h4000}, 0, 0, 0, 10, -1, 0);
    // R7 filler bit set
    runFrame({2'b01, 1'b1, 16'h1234}, 0, 0, 2, 10, -1, 0);
    // R10 no poll while converting
    runFrame({2'b00, 1'b1, 16'h0F0F}, 1, 0, 1, 10, -1, 0);
    // R9 poll then success
    runFrame({2'b00, 1'b0, 16'hC3A5}, 1, 1, 2, 200, 30, 0);
    // R9 poll timeout: code and value hold
    runFrame({2'b00, 1'b1, 16'h5555}, 1, 1, 1, 20, -1, 0);
    // R2 start during a read ignored
    runFrame({2'b00, 1'b1, 16'hABCD}, 0, 0, 2, 10, -1, 1);
    runFrame({2'b00, 1'b0, 16'h8001}, 0, 1, 4, 10, -1, 0);
    if (!finished) begin
      finished = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++; errors++;
      $display("FAIL watchdog run did not end actual 0 expected 1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule